// File: doc/BRIEF.md
# Registered Byte-Lane Write Decode with Behavioural Word Store

This block turns the write controls of a synchronous memory port into one write strobe per byte lane. Three active-low controls are used: a full-word write, a lane-write enable, and one select per lane. The decision is captured in input registers on the rising clock edge, together with the address and the write data. The captured strobes then drive a write into a behavioural word store on the following edge. No further control is needed to finish that write.

When neither the full-word write nor the lane-write enable is active, the cycle is a read. Its address is captured the same way, and the stored word appears on the read port one edge later, with a valid flag. If the lane-write enable is active but no lane is selected, the cycle is void: nothing is written and nothing is read. A host uses the block as the write path and read-back path of a word built from several byte lanes.

Top module: `bw_write_unit`

## Requirements
- R1: With `full_wr_n` low in cycle n, `lane_wr` is all ones in cycle n+1, whatever `lane_en_n` and `lane_sel_n` are.
- R2: With `full_wr_n` high and `lane_en_n` low in cycle n, bit i of `lane_wr` in cycle n+1 is the inverse of `lane_sel_n[i]`. Bit i covers data bits [8i+7:8i] with the default lane width.
- R3: With `full_wr_n` high, `lane_en_n` low and every `lane_sel_n` bit high, no lane is written, `lane_wr` is zero in cycle n+1, and `rd_valid` stays low in cycle n+2.
- R4: With `full_wr_n` and `lane_en_n` both high, the cycle is a read. `lane_wr` is zero in cycle n+1, and `rd_valid` is high in cycle n+2 with `rd_data` equal to the word stored at the captured address.
- R5: Controls, address and data are taken only at the rising edge. Changes after that edge do not alter the write already captured.
- R6: A captured write is committed on the next edge without further inputs. A read issued in the cycle after a write to the same address returns the new data.
- R7: Lanes not written in a cycle keep their previous contents.
- R8: While `rd_valid` is low, `rd_data` holds its last value.
- R9: While reset is active, and until the first captured cycle after its synchronous release, `lane_wr` is zero and `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| full_wr_n | input | 1 | Active-low write of all lanes |
| lane_en_n | input | 1 | Active-low enable for per-lane writes |
| lane_sel_n | input | LANES | Active-low per-lane select, bit i is lane i |
| addr | input | ADDR_W | Word address |
| wr_data | input | LANES*LANE_W | Write data, lane i in bits [LANE_W*i +: LANE_W] |
| lane_wr | output | LANES | Captured lane strobes driving the store this cycle |
| rd_data | output | LANES*LANE_W | Read word |
| rd_valid | output | 1 | High in the cycle `rd_data` carries a new read result |

## Verification
On every cycle, the assertions check how the registered strobes follow the captured controls. They cover full-word priority, the lane-select mapping, the void and read cycles leaving the strobes at zero, the read valid timing, the hold of read data, and the quiet state in reset. Only the bench scenarios can show what ends up in the store. That covers lanes that were not written keeping their bytes, a read right after a write returning the new word, and the returned data matching the captured address. The reference model tracks every word to show this.

// File: rtl/bw_pkg.sv
package bw_pkg;

  // Kind of cycle decoded from the write controls.
  typedef enum logic [1:0] {
    BW_OP_VOID = 2'd0,
    BW_OP_READ = 2'd1,
    BW_OP_LANE = 2'd2,
    BW_OP_FULL = 2'd3
  } bw_op_e;

  // Number of stages in the reset release synchronizer.
  localparam int unsigned BW_RST_STAGES = 2;

endpackage

// File: rtl/bw_rst_sync.sv
module bw_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/bw_strobe_decode.sv
module bw_strobe_decode
  import bw_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic             full_wr_n,
  input  logic             lane_en_n,
  input  logic [LANES-1:0] lane_sel_n,
  output logic [LANES-1:0] stb,
  output logic             rd_req,
  output bw_op_e           op
);

  logic [LANES-1:0] sel_act;

  // Per-lane active-high select, one gate per lane.
  for (genvar i = 0; i < LANES; i++) begin : g_sel
    assign sel_act[i] = ~lane_sel_n[i];
  end

  // Full-word write outranks lane enable, which outranks a read.
  always_comb begin
    op = BW_OP_READ;
    if (!full_wr_n) begin
      op = BW_OP_FULL;
    end else if (!lane_en_n) begin
      op = (|sel_act) ? BW_OP_LANE : BW_OP_VOID;
    end
  end

  always_comb begin
    stb    = '0;
    rd_req = 1'b0;
    unique case (op)
      BW_OP_FULL: stb    = '1;
      BW_OP_LANE: stb    = sel_act;
      BW_OP_READ: rd_req = 1'b1;
      default:    stb    = '0;
    endcase
  end

endmodule

// File: rtl/bw_capture_stage.sv
module bw_capture_stage #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANES-1:0]  stb_d,
  input  logic              rd_d,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic [DATA_W-1:0] data_d,
  output logic [LANES-1:0]  stb_q,
  output logic              rd_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q
);

  logic              cap_en;
  logic [ADDR_W-1:0] addr_nxt;
  logic [DATA_W-1:0] data_nxt;

  // Address and data flops only load when the cycle does something.
  always_comb begin
    cap_en   = rd_d | (|stb_d);
    addr_nxt = addr_q;
    data_nxt = data_q;
    if (cap_en) begin
      addr_nxt = addr_d;
      data_nxt = data_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= '0;
      rd_q  <= 1'b0;
    end else begin
      stb_q <= stb_d;
      rd_q  <= rd_d;
    end
  end

  always_ff @(posedge clk) begin
    addr_q <= addr_nxt;
    data_q <= data_nxt;
  end

endmodule

// File: rtl/bw_lane_array.sv
module bw_lane_array #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned ADDR_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES-1:0]        we,
  input  logic                    re,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rvalid
);

  localparam int unsigned DEPTH  = 1 << ADDR_W;
  localparam int unsigned DATA_W = LANES * LANE_W;

  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] q_nxt;
  logic              v_nxt;

  // One independent store per lane; a lane only loads on its own strobe.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we[i]) begin
        mem[addr] <= wdata[LANE_W*i +: LANE_W];
      end
    end

    assign rd_word[LANE_W*i +: LANE_W] = mem[addr];
  end

  always_comb begin
    v_nxt = re;
    q_nxt = rdata;
    if (re) begin
      q_nxt = rd_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rdata  <= q_nxt;
      rvalid <= v_nxt;
    end
  end

endmodule

// File: rtl/bw_write_unit.sv
module bw_write_unit
  import bw_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned ADDR_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    full_wr_n,
  input  logic                    lane_en_n,
  input  logic [LANES-1:0]        lane_sel_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wr_data,
  output logic [LANES-1:0]        lane_wr,
  output logic [LANES*LANE_W-1:0] rd_data,
  output logic                    rd_valid
);

  localparam int unsigned DATA_W = LANES * LANE_W;

  logic              rst_core_n;
  logic [LANES-1:0]  stb_d;
  logic              rd_d;
  bw_op_e            op_d;
  logic [LANES-1:0]  stb_q;
  logic              rd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  bw_rst_sync #(
    .STAGES(BW_RST_STAGES)
  ) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_core_n)
  );

  bw_strobe_decode #(
    .LANES(LANES)
  ) u_dec (
    .full_wr_n (full_wr_n),
    .lane_en_n (lane_en_n),
    .lane_sel_n(lane_sel_n),
    .stb       (stb_d),
    .rd_req    (rd_d),
    .op        (op_d)
  );

  bw_capture_stage #(
    .LANES (LANES),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_cap (
    .clk   (clk),
    .rst_n (rst_core_n),
    .stb_d (stb_d),
    .rd_d  (rd_d),
    .addr_d(addr),
    .data_d(wr_data),
    .stb_q (stb_q),
    .rd_q  (rd_q),
    .addr_q(addr_q),
    .data_q(data_q)
  );

  bw_lane_array #(
    .LANES (LANES),
    .LANE_W(LANE_W),
    .ADDR_W(ADDR_W)
  ) u_arr (
    .clk   (clk),
    .rst_n (rst_core_n),
    .we    (stb_q),
    .re    (rd_q),
    .addr  (addr_q),
    .wdata (data_q),
    .rdata (rd_data),
    .rvalid(rd_valid)
  );

  assign lane_wr = stb_q;

  logic unused_op;
  assign unused_op = ^op_d;

endmodule

// File: rtl/bw_write_unit_chk.sv
module bw_write_unit_chk #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              full_wr_n,
  input logic              lane_en_n,
  input logic [LANES-1:0]  lane_sel_n,
  input logic [LANES-1:0]  lane_wr,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid
);

  logic armed_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
    end
  end

  // R1
  full_all_lanes_chk: assert property (@(posedge clk) disable iff (!armed_q)
    !$past(full_wr_n) |-> (lane_wr == {LANES{1'b1}}));

  // R2
  lane_map_chk: assert property (@(posedge clk) disable iff (!armed_q)
    ($past(full_wr_n) && !$past(lane_en_n)) |-> (lane_wr == ~$past(lane_sel_n)));

  // R3
  void_quiet_chk: assert property (@(posedge clk) disable iff (!armed_q)
    ($past(full_wr_n) && !$past(lane_en_n) && (&$past(lane_sel_n)))
      |-> (lane_wr == '0) ##1 !rd_valid);

  // R4
  read_no_write_chk: assert property (@(posedge clk) disable iff (!armed_q)
    ($past(full_wr_n) && $past(lane_en_n)) |-> (lane_wr == '0) ##1 rd_valid);

  // R8
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!armed_q)
    !rd_valid |-> $stable(rd_data));

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_sync_n |-> (lane_wr == '0 && !rd_valid));

endmodule

bind bw_write_unit bw_write_unit_chk #(
  .LANES (LANES),
  .DATA_W(LANES*LANE_W)
) u_chk (
  .clk       (clk),
  .rst_sync_n(rst_core_n),
  .full_wr_n (full_wr_n),
  .lane_en_n (lane_en_n),
  .lane_sel_n(lane_sel_n),
  .lane_wr   (lane_wr),
  .rd_data   (rd_data),
  .rd_valid  (rd_valid)
);

// File: tb/bw_write_unit_test.sv
`timescale 1ns/1ps
module bw_write_unit_test;

  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int ADDR_W = 6;
  localparam int DW     = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk;
  logic              rst_n;
  logic              full_wr_n;
  logic              lane_en_n;
  logic [LANES-1:0]  lane_sel_n;
  logic [ADDR_W-1:0] addr;
  logic [DW-1:0]     wr_data;
  logic [LANES-1:0]  lane_wr;
  logic [DW-1:0]     rd_data;
  logic              rd_valid;

  int n_cmp;
  int n_bad;
  bit live;

  bw_write_unit #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .full_wr_n(full_wr_n), .lane_en_n(lane_en_n),
    .lane_sel_n(lane_sel_n), .addr(addr), .wr_data(wr_data),
    .lane_wr(lane_wr), .rd_data(rd_data), .rd_valid(rd_valid));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Behavioural reference: captured cycle plus a word store.
  logic [DW-1:0]    m_mem [DEPTH];
  logic [LANES-1:0] m_stb;
  bit               m_rd;
  int               m_addr;
  logic [DW-1:0]    m_data;
  string            m_tag;
  bit               m_rv;
  logic [DW-1:0]    m_q;

  initial begin
    m_stb = '0; m_rd = 0; m_addr = 0; m_data = '0; m_tag = "R9"; m_rv = 0; m_q = '0;
  end

  always @(posedge clk) begin
    // stage 2: read then commit the earlier captured write
    m_rv = m_rd;
    if (m_rd) m_q = m_mem[m_addr];
    for (int i = 0; i < LANES; i++)
      if (m_stb[i]) m_mem[m_addr][LANE_W*i +: LANE_W] = m_data[LANE_W*i +: LANE_W];
    // stage 1: capture at the edge (R5)
    m_rd = 0; m_stb = '0;
    if (!full_wr_n) begin
      m_stb = '1; m_tag = "R1";
    end else if (!lane_en_n) begin
      m_stb = ~lane_sel_n;
      m_tag = (lane_sel_n == '1) ? "R3" : "R2";
    end else begin
      m_rd = 1; m_tag = "R4";
    end
    if (m_rd || m_stb != '0) begin
      m_addr = int'(addr); m_data = wr_data;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(lane_wr == '0, "R9 lane_wr in reset", DW'(lane_wr), '0);
      chk(!rd_valid, "R9 rd_valid in reset", DW'(rd_valid), '0);
    end else if (live) begin
      chk(lane_wr == m_stb, {m_tag, " R5 lane_wr"}, DW'(lane_wr), DW'(m_stb));
      chk(rd_valid == m_rv, "R4 R3 rd_valid", DW'(rd_valid), DW'(m_rv));
      if (m_rv) chk(rd_data == m_q, "R6 R7 rd_data", rd_data, m_q);
      else      chk(rd_data == m_q, "R8 rd_data hold", rd_data, m_q);
    end
  end

  task automatic drive(input bit f, input bit e, input logic [LANES-1:0] s,
                       input int a, input logic [DW-1:0] d);
    @(negedge clk);
    full_wr_n = f; lane_en_n = e; lane_sel_n = s;
    addr = ADDR_W'(a); wr_data = d;
  endtask

  task automatic nul();
    drive(1, 0, '1, 0, '0);
  endtask

  task automatic rd(input int a);
    drive(1, 1, '1, a, $urandom());
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    n_cmp = 0; n_bad = 0; live = 0;
    rst_n = 1'b0;
    full_wr_n = 1; lane_en_n = 0; lane_sel_n = '1; addr = '0; wr_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) nul();
    live = 1;
    // fill every word with a full write (R1, with lane controls ignored)
    for (int a = 0; a < DEPTH; a++)
      drive(0, a[0], LANES'(a), a, {8'hA5, 8'(a), 8'h3C, 8'(~a)});
    // R2, R7: single lanes then read back
    for (int i = 0; i < LANES; i++) begin
      drive(1, 0, ~(LANES'(1) << i), 5, 32'h11223344 + i);
      rd(5);
    end
    // R6: write then immediate read of same address
    drive(1, 0, 4'b1010, 9, 32'hDEADBEEF);
    rd(9);
    // R3: enable with no select, then read that word unchanged
    drive(1, 0, '1, 9, 32'h0);
    rd(9);
    // R1: full write with enable active and some selects high
    drive(0, 0, 4'b0110, 12, 32'hCAFEF00D);
    rd(12);
    // R5: back-to-back writes to one address
    drive(0, 1, '1, 20, 32'h01010101);
    drive(1, 0, 4'b1100, 20, 32'hFFFFFFFF);
    rd(20);
    nul(); nul();
    // mixed random traffic
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 15)      drive(0, $urandom_range(0,1) == 1, LANES'($urandom()), int'($urandom_range(0, DEPTH-1)), $urandom());
      else if (r < 55) drive(1, 0, LANES'($urandom()), int'($urandom_range(0, DEPTH-1)), $urandom());
      else             rd(int'($urandom_range(0, DEPTH-1)));
    end
    repeat (4) nul();
    summary();
  end

endmodule